// File: doc/BRIEF.md
# Multichannel Audio Frame Multiplexer

This block builds the serial payload of a multichannel digital audio link. Each sampling period it sends one frame of 56 mono channels. Each channel occupies a 32-bit time slot laid out like a two-channel audio subframe. The slot has a 4-bit header, a 24-bit sample, and validity, user, channel-status and parity bits. The header bits do not carry a sync preamble here. They carry per-channel control flags: a frame-first marker, a channel-active flag, an A/B link flag and a sync flag. The block emits one bit per `bit_en` strobe, bit 0 of each slot first and channel 0 first. It marks the first bit of every frame with a `frame_start` pulse. Its output feeds a downstream line coder.

Software or an upstream audio engine writes per-channel samples, the V/U/C bits and an active flag into a double buffer. The buffer has two banks of 56 entries. Writes always land in the back bank. The banks swap on the last bit of a frame, so each transmitted frame is built from one consistent set of channel data. The two link flags are sampled at the same frame boundary and stay fixed for the whole next frame. Line coding, the physical medium and clock recovery belong to other blocks.

Top module: `mcaf_mux`

## Requirements
- R1: After reset `ser_vld`, `frame_start` and `ser_bit` are 0, both buffer banks read as inactive all-zero channels, and both link flags used in the first frame are 0.
- R2: A frame is 56 slots of 32 bits, channels 0 to 55 in rising order. Each slot is sent bit 0 first. Sample bit k sits at slot bit 4+k (sample LSB first). V sits at bit 28, U at bit 29, C at bit 30 and parity at bit 31.
- R3: Slot bit 0 is 1 in channel 0 and 0 in every other channel.
- R4: Slot bit 1 carries the channel-active flag. An inactive channel is still sent in its slot, with bit 1 clear and all 24 sample bits zero. Its V, U and C bits are sent as written.
- R5: Slot bit 2 carries the A/B flag (`link_ab`) and slot bit 3 carries the sync flag (`link_sync`). Both are sampled on the last bit of the previous frame and are identical in every slot of a frame.
- R6: Slot bit 31 makes the number of ones in slot bits 4 to 31 even.
- R7: `frame_start` is high together with `ser_vld` on bit 0 of channel 0 and is low at every other time.
- R8: Each cycle with `bit_en` high produces exactly one output bit. `ser_vld` equals `bit_en` delayed by one cycle. Cycles with `bit_en` low produce no bit and do not advance the frame position.
- R9: A write lands in the back bank and first appears in the frame that begins after the next frame boundary. A write made during a frame never changes the frame in progress.
- R10: A channel that is not rewritten keeps, in each bank, the value last written to that bank. After two swaps it therefore reappears unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe: one output bit per high cycle |
| wr_en | input | 1 | Write strobe for the back bank |
| wr_ch | input | CH_W (6) | Channel number of the write (0 to 55) |
| wr_sample | input | 24 | Audio sample to store |
| wr_active | input | 1 | Channel-active flag to store |
| wr_valid | input | 1 | Validity bit to store |
| wr_user | input | 1 | User bit to store |
| wr_chst | input | 1 | Channel-status bit to store |
| link_ab | input | 1 | A/B link flag, sampled at each frame boundary |
| link_sync | input | 1 | Sync flag, sampled at each frame boundary |
| ser_bit | output | 1 | Serial data bit |
| ser_vld | output | 1 | `ser_bit` holds a new bit this cycle |
| frame_start | output | 1 | First bit of channel 0 |

## Verification
The bench keeps its own two-bank model of the buffer. It predicts every slot of five frames and compares header, data and parity fields separately.

The bench drives the strobe three ways: every cycle, every other cycle, and an irregular gapped pattern. A design that advanced its position on idle cycles would shift whole slots, and a `ser_vld` that did not track the strobe would show up in the per-frame check.

Writes are placed in the middle of a frame. A design that wrote the front bank, or swapped at a slot edge instead of the frame edge, would corrupt the frame in progress. Channel 5 is rewritten in one bank only. A design that cleared the bank on a swap, or shared storage between the banks, would then show the wrong value two frames later.

The bench also writes marked channels as inactive but with non-zero samples. All-ones and all-zero samples exercise the parity, and leaking audio or a flag in the wrong header bit would fail the R4 and R5 fields.

// File: rtl/mcaf_pkg.sv
package mcaf_pkg;
  localparam int SAMPLE_W = 24;
  localparam int HDR_W    = 4;
  localparam int TAIL_W   = 4;
  localparam int SLOT_W   = HDR_W + SAMPLE_W + TAIL_W;

  // header flag positions (decoded by the receiver)
  localparam int FIRST_POS = 0;
  localparam int ACT_POS   = 1;
  localparam int AB_POS    = 2;
  localparam int SYNC_POS  = 3;
  // tail positions
  localparam int V_POS     = HDR_W + SAMPLE_W;
  localparam int U_POS     = V_POS + 1;
  localparam int C_POS     = V_POS + 2;
  localparam int PAR_POS   = V_POS + 3;

  typedef struct packed {
    logic                active;
    logic                v;
    logic                u;
    logic                c;
    logic [SAMPLE_W-1:0] sample;
  } ch_entry_t;

  // even parity over the sample and status portion
  function automatic logic even_par(input logic [SLOT_W-1:0] w);
    return ^w[PAR_POS-1:HDR_W];
  endfunction

  function automatic logic [SLOT_W-1:0] pack_slot(
    input logic      first,
    input logic      ab,
    input logic      sync,
    input ch_entry_t e
  );
    logic [SLOT_W-1:0] w;
    w                       = '0;
    w[FIRST_POS]            = first;
    w[ACT_POS]              = e.active;
    w[AB_POS]               = ab;
    w[SYNC_POS]             = sync;
    w[HDR_W +: SAMPLE_W]    = e.active ? e.sample : '0;
    w[V_POS]                = e.v;
    w[U_POS]                = e.u;
    w[C_POS]                = e.c;
    w[PAR_POS]              = even_par(w);
    return w;
  endfunction
endpackage

// File: rtl/mcaf_bank.sv
module mcaf_bank
  import mcaf_pkg::*;
#(
  parameter int NUM_CH = 56,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  ch_entry_t       wr_data,
  input  logic            swap,
  input  logic [CH_W-1:0] rd_ch,
  output ch_entry_t       rd_data
);
  localparam int NBANK = 2;

  logic             front_sel;
  logic             wr_ok;
  logic [NBANK-1:0] bank_we;
  ch_entry_t        bank_out [NBANK];

  assign wr_ok = wr_en && (int'(wr_ch) < NUM_CH);

  always_ff @(posedge clk) begin
    if (!rst_n)    front_sel <= 1'b0;
    else if (swap) front_sel <= ~front_sel;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ch_entry_t store [NUM_CH];

    assign bank_we[b] = wr_ok && (front_sel != 1'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < NUM_CH; i++) store[i] <= '0;
      end else if (bank_we[b]) begin
        store[wr_ch] <= wr_data;
      end
    end

    assign bank_out[b] = store[rd_ch];
  end

  assign rd_data = bank_out[front_sel];

  // R9
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> front_sel != $past(front_sel));
  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(front_sel));
  // R9
  front_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bank_we[0] && !front_sel) && !(bank_we[1] && front_sel));
endmodule

// File: rtl/mcaf_seq.sv
module mcaf_seq #(
  parameter int NUM_CH = 56,
  parameter int SLOT_W = 32,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int BIT_W  = $clog2(SLOT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  output logic [CH_W-1:0]  ch_idx,
  output logic [BIT_W-1:0] bit_idx,
  output logic             at_frame_head,
  output logic             slot_done,
  output logic             frame_done
);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NUM_CH - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_W - 1);

  assign at_frame_head = (ch_idx == '0) && (bit_idx == '0);
  assign slot_done     = bit_en && (bit_idx == LAST_BIT);
  assign frame_done    = slot_done && (ch_idx == LAST_CH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_idx  <= '0;
      bit_idx <= '0;
    end else if (bit_en) begin
      if (slot_done) begin
        bit_idx <= '0;
        ch_idx  <= frame_done ? '0 : ch_idx + 1'b1;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ch_idx) && $stable(bit_idx));
  // R2
  ch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done && !frame_done |=> ch_idx == CH_W'($past(ch_idx) + 1'b1) && bit_idx == '0);
  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> at_frame_head);
endmodule

// File: rtl/mcaf_fmt.sv
module mcaf_fmt
  import mcaf_pkg::*;
(
  input  logic              first,
  input  logic              ab,
  input  logic              sync,
  input  ch_entry_t         entry,
  output logic [SLOT_W-1:0] slot_word
);
  assign slot_word = pack_slot(first, ab, sync, entry);
endmodule

// File: rtl/mcaf_mux.sv
module mcaf_mux
  import mcaf_pkg::*;
#(
  parameter int NUM_CH = 56,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_en,
  input  logic                wr_en,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [SAMPLE_W-1:0] wr_sample,
  input  logic                wr_active,
  input  logic                wr_valid,
  input  logic                wr_user,
  input  logic                wr_chst,
  input  logic                link_ab,
  input  logic                link_sync,
  output logic                ser_bit,
  output logic                ser_vld,
  output logic                frame_start
);
  localparam int BIT_W = $clog2(SLOT_W);

  logic [CH_W-1:0]   ch_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic              at_frame_head;
  logic              slot_done;
  logic              frame_done;
  logic              first_ch;
  logic              ab_q, sync_q;
  ch_entry_t         wr_entry;
  ch_entry_t         cur_entry;
  logic [SLOT_W-1:0] slot_word;

  assign wr_entry = '{active: wr_active, v: wr_valid, u: wr_user,
                      c: wr_chst, sample: wr_sample};
  assign first_ch = (ch_idx == '0);

  mcaf_seq #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CH_W(CH_W), .BIT_W(BIT_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_en        (bit_en),
    .ch_idx        (ch_idx),
    .bit_idx       (bit_idx),
    .at_frame_head (at_frame_head),
    .slot_done     (slot_done),
    .frame_done    (frame_done)
  );

  mcaf_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_data (wr_entry),
    .swap    (frame_done),
    .rd_ch   (ch_idx),
    .rd_data (cur_entry)
  );

  mcaf_fmt u_fmt (
    .first     (first_ch),
    .ab        (ab_q),
    .sync      (sync_q),
    .entry     (cur_entry),
    .slot_word (slot_word)
  );

  // link flags held for a whole frame
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ab_q   <= 1'b0;
      sync_q <= 1'b0;
    end else if (frame_done) begin
      ab_q   <= link_ab;
      sync_q <= link_sync;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_bit     <= 1'b0;
      ser_vld     <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      ser_vld     <= bit_en;
      frame_start <= bit_en && at_frame_head;
      if (bit_en) ser_bit <= slot_word[bit_idx];
    end
  end

  // R7
  frame_start_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ser_vld);
  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ser_vld == $past(bit_en));
  // R6
  slot_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ^slot_word[SLOT_W-1:HDR_W] == 1'b0);
  // R3
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_word[FIRST_POS] == (ch_idx == '0));
  // R4
  inactive_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_word[ACT_POS] |-> slot_word[HDR_W +: SAMPLE_W] == '0);
  // R5
  link_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(ab_q) && $stable(sync_q));
endmodule

// File: tb/mcaf_mux_tb.sv
module mcaf_mux_tb;
  localparam int NCH = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_ch = '0;
  logic [23:0] wr_sample = '0;
  logic wr_active = 1'b0, wr_valid = 1'b0, wr_user = 1'b0, wr_chst = 1'b0;
  logic link_ab = 1'b0, link_sync = 1'b0;
  logic ser_bit, ser_vld, frame_start;

  always #2 clk = ~clk;  // 250 MHz

  mcaf_mux u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
    .wr_en(wr_en), .wr_ch(wr_ch), .wr_sample(wr_sample),
    .wr_active(wr_active), .wr_valid(wr_valid), .wr_user(wr_user),
    .wr_chst(wr_chst), .link_ab(link_ab), .link_sync(link_sync),
    .ser_bit(ser_bit), .ser_vld(ser_vld), .frame_start(frame_start)
  );

  typedef struct packed {
    logic act; logic v; logic u; logic c; logic [23:0] s;
  } ent_t;

  int   n_checks = 0;
  int   n_fail   = 0;
  ent_t mdl [2][NCH];
  int   mdl_front = 0;
  logic ab_lat = 1'b0, sync_lat = 1'b0;
  logic [31:0] exp_q [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected slot, assembled bit by bit
  function automatic logic [31:0] exp_word(input int ch, input ent_t e,
                                           input logic ab, input logic sy);
    logic [31:0] w;
    int ones;
    w = '0;
    w[0] = (ch == 0);
    w[1] = e.act;
    w[2] = ab;
    w[3] = sy;
    for (int k = 0; k < 24; k++) w[4 + k] = e.act & e.s[k];
    w[28] = e.v;
    w[29] = e.u;
    w[30] = e.c;
    ones = 0;
    for (int k = 4; k < 31; k++) ones += int'(w[k]);
    w[31] = (ones % 2) == 1;
    return w;
  endfunction

  task automatic push_frame();
    for (int ch = 0; ch < NCH; ch++)
      exp_q.push_back(exp_word(ch, mdl[mdl_front][ch], ab_lat, sync_lat));
  endtask

  // driver: write one channel into the back bank and the model
  task automatic write_ch(input int ch, input logic act, input logic [23:0] s,
                          input logic v, input logic u, input logic c);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 6'(ch); wr_sample = s;
    wr_active = act; wr_valid = v; wr_user = u; wr_chst = c;
    mdl[1 - mdl_front][ch] = '{act: act, v: v, u: u, c: c, s: s};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frame_start();
    do @(negedge clk); while (!frame_start);
  endtask

  // bit strobe generator
  int  en_mode = 0;
  bit  run = 1'b0;
  int  gen_cyc = 0;
  always @(negedge clk) begin
    gen_cyc <= gen_cyc + 1;
    if (!run)              bit_en <= 1'b0;
    else if (en_mode == 0) bit_en <= 1'b1;
    else if (en_mode == 1) bit_en <= gen_cyc[0];
    else                   bit_en <= (gen_cyc % 5 == 0) || (gen_cyc % 5 == 3);
  end

  // monitor / scoreboard
  int  mon_bit = 0, mon_ch = 0, frame_idx = 0;
  int  fs_err = 0, vld_err = 0;
  logic [31:0] acc = '0;
  always @(negedge clk) begin
    if (rst_n && run) begin
      if (ser_vld !== bit_en) vld_err++;
      if (frame_start && !(ser_vld && mon_bit == 0 && mon_ch == 0)) fs_err++;
      if (ser_vld) begin
        if (mon_bit == 0 && mon_ch == 0)
          check(frame_start === 1'b1, "R7", "frame_start on ch0 bit0",
                32'(frame_start), 32'd1);
        acc[mon_bit] = ser_bit;
        if (mon_bit == 31) begin
          logic [31:0] e;
          string dtag;
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "scoreboard empty", acc, 32'd0);
            e = '0;
          end else e = exp_q.pop_front();
          if (!e[1])               dtag = "R4";
          else if (frame_idx == 0) dtag = "R1";
          else if (frame_idx == 1) dtag = "R9";
          else if (frame_idx == 3) dtag = "R10";
          else                     dtag = "R2";
          check(acc[0] === e[0], "R3", $sformatf("first flag ch%0d", mon_ch),
                32'(acc[0]), 32'(e[0]));
          check(acc[1] === e[1], "R4", $sformatf("active flag ch%0d", mon_ch),
                32'(acc[1]), 32'(e[1]));
          check(acc[3:2] === e[3:2], "R5", $sformatf("link flags ch%0d", mon_ch),
                32'(acc[3:2]), 32'(e[3:2]));
          check(acc[30:4] === e[30:4], dtag, $sformatf("data ch%0d f%0d", mon_ch, frame_idx),
                32'(acc[30:4]), 32'(e[30:4]));
          check(acc[31] === e[31], "R6", $sformatf("parity ch%0d", mon_ch),
                32'(acc[31]), 32'(e[31]));
          mon_bit = 0;
          mon_ch++;
          if (mon_ch == NCH) begin
            mon_ch = 0;
            check(vld_err == 0, "R8", "ser_vld tracks bit_en", 32'(vld_err), 32'd0);
            check(fs_err == 0, "R7", "stray frame_start", 32'(fs_err), 32'd0);
            vld_err = 0;
            fs_err = 0;
            frame_idx++;
            mdl_front = 1 - mdl_front;
            ab_lat = link_ab;
            sync_lat = link_sync;
            push_frame();
          end
        end else mon_bit++;
      end
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual frames %0d expected 5", frame_idx);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int ch = 0; ch < NCH; ch++) mdl[b][ch] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(ser_vld === 1'b0, "R1", "ser_vld after reset", 32'(ser_vld), 32'd0);
    check(frame_start === 1'b0, "R1", "frame_start after reset", 32'(frame_start), 32'd0);
    check(ser_bit === 1'b0, "R1", "ser_bit after reset", 32'(ser_bit), 32'd0);
    // R8: no strobe, no bits
    repeat (5) @(negedge clk);
    check(ser_vld === 1'b0, "R8", "idle without bit_en", 32'(ser_vld), 32'd0);
    push_frame();
    run = 1'b1;
    en_mode = 0;

    // frame 0: fill the back bank with a full pattern
    wait_frame_start();
    for (int ch = 0; ch < NCH; ch++) begin
      logic [23:0] s;
      s = {ch[7:0], ~ch[7:0], 8'(ch * 37 + 5)};
      if (ch == 1)  s = 24'hFFFFFF;
      if (ch == 2)  s = 24'h000000;
      if (ch == 55) s = 24'h800001;
      write_ch(ch, (ch % 7) != 3, s, ch[0], ch[1], ch[2]);
    end
    link_ab = 1'b1;
    link_sync = 1'b0;

    // frame 1: mid-frame writes must not disturb it (R9)
    wait_frame_start();
    write_ch(0, 1'b1, 24'hA5A5A5, 1'b1, 1'b1, 1'b1);
    write_ch(10, 1'b0, 24'h123456, 1'b0, 1'b1, 1'b0);
    write_ch(55, 1'b1, 24'h7FFFFE, 1'b0, 1'b0, 1'b1);
    link_ab = 1'b0;
    link_sync = 1'b1;
    en_mode = 1;

    // frame 2: only channel 5 changes in the other bank (R10)
    wait_frame_start();
    write_ch(5, 1'b1, 24'h0F0F0F, 1'b1, 1'b0, 1'b0);
    link_ab = 1'b1;
    link_sync = 1'b1;
    en_mode = 2;

    wait_frame_start();
    wait_frame_start();
    while (frame_idx < 5) @(negedge clk);
    run = 1'b0;
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule